// File: doc/BRIEF.md
# Simultaneous-Sample Acquisition Group Sequencer

This block sequences one acquisition group for a multi-channel converter front end. When a trigger arrives it asserts a hold strobe so that every channel's sample-and-hold captures at the same instant. It then converts the held channels one at a time, starting at channel 0, by driving a channel select and a one-cycle convert-start pulse to an external converter. The converted 11-bit word from each channel is captured into a holding register of its own.

A group covers 2, 3 or 4 channels, and its duration is exact to the cycle. The hold phase lasts 20 clocks and each conversion lasts 40 clocks, so a group takes 100, 140 or 180 clocks. Three sources can trigger a group: a host command, the rising edge of an external convert-start pin, and a PWM synchronisation pulse, which counts only while it is enabled. The host reads the holding registers in any order through a read select. Each result is presented as a 12-bit two's complement word: by default it is sign-extended, and a build parameter selects left alignment instead. A done pulse marks the cycle in which the whole group's results are visible.

Top module: `adc_group_seq`

## Requirements
- R1: `grp_size` selects the channel count when the group starts: code 0 gives 2 channels, code 1 gives 3, and codes 2 and 3 both give 4.
- R2: The cycle after the clock edge that accepts a trigger, `hold_o` rises and stays high for exactly 20 cycles. It occurs once per group, before any conversion.
- R3: Each channel conversion lasts 40 cycles. `conv_start_o` is high only in the first cycle of each conversion. In that cycle `ch_sel_o` equals the channel index, which runs 0, 1, … up to N-1. `ch_sel_o` is stable for the whole conversion.
- R4: `busy_o` stays high for exactly 20 + 40·N cycles, which is 100, 140 or 180.
- R5: The result for channel k is the `conv_data_i` value present in the last cycle of channel k's conversion window.
- R6: `rd_data` combinationally shows the register selected by `rd_sel`, sign-extended from 11 to 12 bits. The registers can be read in any order, and the order does not change what is read.
- R7: A group starts on a clock edge at which `start_cmd` is high, at which `start_pin` has risen since the previous edge, or at which `pwm_sync` and `sync_en` are both high. While `sync_en` is low, `pwm_sync` starts nothing.
- R8: Any trigger that arrives while `busy_o` is high is dropped. It is not queued, so `busy_o` stays low after the group ends.
- R9: `done_o` is a one-cycle pulse in the first cycle after `busy_o` falls. In that same cycle the last result is already readable.
- R10: After reset, `busy_o`, `hold_o`, `conv_start_o` and `done_o` are low, and every result register reads 0.
- R11: A change on `grp_size` while a group is running has no effect on that group's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_cmd | input | 1 | Host start command, acted on when high |
| start_pin | input | 1 | External convert-start pin; the rising edge triggers |
| pwm_sync | input | 1 | PWM period synchronisation pulse |
| sync_en | input | 1 | Enables `pwm_sync` as a trigger |
| grp_size | input | 2 | Group size code (see R1) |
| conv_data_i | input | 11 | Word returned by the external converter |
| rd_sel | input | 2 | Result register select for host reads |
| hold_o | output | 1 | Common sample-and-hold strobe |
| conv_start_o | output | 1 | Convert-start pulse to the converter |
| ch_sel_o | output | 2 | Channel being converted |
| busy_o | output | 1 | A group is in progress |
| done_o | output | 1 | Group finished, all results written |
| rd_data | output | 12 | Selected result as a 12-bit two's complement word |

## Verification
The hardest case to produce is a trigger, or a size change, that lands in the middle of a running group. Such an event should leave no trace, yet a design that queued it would differ only after the group ended. Every group in the sweep therefore receives a size change, a host command and an enabled PWM pulse while it is busy. The bench then counts hold, busy and convert-start cycles and confirms that `busy_o` stays low once the group is over. The converter model returns a word that changes every cycle, so a capture made one cycle early or late gives a different result.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HOLD = 2'd1,
        PH_CONV = 2'd2
    } phase_e;

    // Index of the last channel converted for a group size code.
    function automatic int unsigned last_ch_of(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 2;
            default: return 3;
        endcase
    endfunction

endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic start_cmd,
    input  logic start_pin,
    input  logic pwm_sync,
    input  logic sync_en,
    output logic trig
);

    typedef struct packed {
        logic pin;
    } trig_state_t;

    trig_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.pin = start_pin;
        trig    = start_cmd | (start_pin & ~s_q.pin) | (pwm_sync & sync_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
    parameter int unsigned MAX_CH   = 4,
    parameter int unsigned HOLD_CYC = 20,
    parameter int unsigned CONV_CYC = 40,
    localparam int unsigned CH_W    = $clog2(MAX_CH),
    localparam int unsigned LONGEST = (HOLD_CYC > CONV_CYC) ? HOLD_CYC : CONV_CYC,
    localparam int unsigned CNT_W   = $clog2(LONGEST + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trig,
    input  logic [1:0]      grp_code,
    output logic            hold,
    output logic            conv_start,
    output logic [CH_W-1:0] ch_sel,
    output logic            busy,
    output logic            wr_en,
    output logic            done
);
    import adc_seq_pkg::*;

    typedef struct packed {
        phase_e          phase;
        logic [CNT_W-1:0] cnt;
        logic [CH_W-1:0]  ch;
        logic [CH_W-1:0]  last;
        logic             done;
    } ctrl_state_t;

    localparam logic [CNT_W-1:0] HOLD_END = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] CONV_END = CNT_W'(CONV_CYC - 1);

    ctrl_state_t s_d, s_q;
    int unsigned lc;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        lc       = last_ch_of(grp_code);
        if (lc > MAX_CH - 1) lc = MAX_CH - 1;
        case (s_q.phase)
            PH_IDLE: begin
                if (trig) begin
                    s_d.phase = PH_HOLD;
                    s_d.cnt   = '0;
                    s_d.ch    = '0;
                    s_d.last  = CH_W'(lc);
                end
            end
            PH_HOLD: begin
                if (s_q.cnt == HOLD_END) begin
                    s_d.phase = PH_CONV;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PH_CONV: begin
                if (s_q.cnt == CONV_END) begin
                    s_d.cnt = '0;
                    if (s_q.ch == s_q.last) begin
                        s_d.phase = PH_IDLE;
                        s_d.done  = 1'b1;
                    end else begin
                        s_d.ch = s_q.ch + 1'b1;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{phase: PH_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign hold       = (s_q.phase == PH_HOLD);
    assign busy       = (s_q.phase != PH_IDLE);
    assign conv_start = (s_q.phase == PH_CONV) && (s_q.cnt == '0);
    assign wr_en      = (s_q.phase == PH_CONV) && (s_q.cnt == CONV_END);
    assign ch_sel     = s_q.ch;
    assign done       = s_q.done;

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int unsigned MAX_CH     = 4,
    parameter int unsigned RES_W      = 11,
    parameter int unsigned HOST_W     = 12,
    parameter bit          LEFT_ALIGN = 1'b0,
    localparam int unsigned CH_W      = $clog2(MAX_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [RES_W-1:0]  wr_data,
    input  logic [CH_W-1:0]   rd_sel,
    output logic [HOST_W-1:0] rd_data
);

    typedef struct packed {
        logic [MAX_CH-1:0][RES_W-1:0] res;
    } bank_state_t;

    bank_state_t s_d, s_q;
    logic [RES_W-1:0] picked;

    always_comb begin
        s_d = s_q;
        if (wr_en) s_d.res[wr_ch] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign picked = s_q.res[rd_sel];

    generate
        if (LEFT_ALIGN) begin : g_left
            assign rd_data = {picked, {(HOST_W - RES_W){1'b0}}};
        end else begin : g_sext
            assign rd_data = {{(HOST_W - RES_W){picked[RES_W-1]}}, picked};
        end
    endgenerate

endmodule

// File: rtl/adc_group_seq.sv
module adc_group_seq #(
    parameter int unsigned MAX_CH     = 4,
    parameter int unsigned RES_W      = 11,
    parameter int unsigned HOST_W     = 12,
    parameter int unsigned HOLD_CYC   = 20,
    parameter int unsigned CONV_CYC   = 40,
    parameter bit          LEFT_ALIGN = 1'b0,
    localparam int unsigned CH_W      = $clog2(MAX_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_cmd,
    input  logic              start_pin,
    input  logic              pwm_sync,
    input  logic              sync_en,
    input  logic [1:0]        grp_size,
    input  logic [RES_W-1:0]  conv_data_i,
    input  logic [CH_W-1:0]   rd_sel,
    output logic              hold_o,
    output logic              conv_start_o,
    output logic [CH_W-1:0]   ch_sel_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [HOST_W-1:0] rd_data
);

    logic trig;
    logic wr_en;

    adc_trig_sel u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_cmd (start_cmd),
        .start_pin (start_pin),
        .pwm_sync  (pwm_sync),
        .sync_en   (sync_en),
        .trig      (trig)
    );

    adc_seq_ctrl #(
        .MAX_CH   (MAX_CH),
        .HOLD_CYC (HOLD_CYC),
        .CONV_CYC (CONV_CYC)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig       (trig),
        .grp_code   (grp_size),
        .hold       (hold_o),
        .conv_start (conv_start_o),
        .ch_sel     (ch_sel_o),
        .busy       (busy_o),
        .wr_en      (wr_en),
        .done       (done_o)
    );

    adc_result_bank #(
        .MAX_CH     (MAX_CH),
        .RES_W      (RES_W),
        .HOST_W     (HOST_W),
        .LEFT_ALIGN (LEFT_ALIGN)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ch   (ch_sel_o),
        .wr_data (conv_data_i),
        .rd_sel  (rd_sel),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/adc_group_seq_chk.sv
module adc_group_seq_chk #(
    parameter int unsigned HOLD_CYC = 20,
    parameter int unsigned CH_W     = 2,
    localparam int unsigned HC_W    = $clog2(HOLD_CYC + 1) + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            hold_o,
    input logic            conv_start_o,
    input logic [CH_W-1:0] ch_sel_o,
    input logic            busy_o,
    input logic            done_o
);

    logic [HC_W-1:0] hcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hcnt <= '0;
        else if (hold_o) hcnt <= hcnt + 1'b1;
        else             hcnt <= '0;
    end

    assert_hold_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_o) |-> (hcnt == HC_W'(HOLD_CYC)));

    assert_hold_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |-> (hcnt < HC_W'(HOLD_CYC)));

    assert_start_from_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> hold_o);

    assert_conv_in_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |-> (busy_o && !hold_o));

    assert_chan_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !hold_o && !conv_start_o) |-> $stable(ch_sel_o));

    assert_done_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!hold_o && !conv_start_o));

endmodule

bind adc_group_seq adc_group_seq_chk #(
    .HOLD_CYC (HOLD_CYC),
    .CH_W     (CH_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hold_o       (hold_o),
    .conv_start_o (conv_start_o),
    .ch_sel_o     (ch_sel_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
);

// File: tb/adc_group_seq_bench.sv
module adc_group_seq_bench;

    localparam int PERIOD = 10;
    localparam int HOLD   = 20;
    localparam int CONV   = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_cmd = 1'b0;
    logic        start_pin = 1'b0;
    logic        pwm_sync = 1'b0;
    logic        sync_en = 1'b0;
    logic [1:0]  grp_size = 2'd0;
    logic [10:0] conv_data_i = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic        hold_o, conv_start_o, busy_o, done_o;
    logic [1:0]  ch_sel_o;
    logic [11:0] rd_data;

    int errs = 0;
    int checks = 0;

    always #(PERIOD / 2) clk = ~clk;

    adc_group_seq u_adc_group_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_cmd    (start_cmd),
        .start_pin    (start_pin),
        .pwm_sync     (pwm_sync),
        .sync_en      (sync_en),
        .grp_size     (grp_size),
        .conv_data_i  (conv_data_i),
        .rd_sel       (rd_sel),
        .hold_o       (hold_o),
        .conv_start_o (conv_start_o),
        .ch_sel_o     (ch_sel_o),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .rd_data      (rd_data)
    );

    // Converter model: a word that changes every cycle and with the channel.
    function automatic logic [10:0] conv_word(input longint idx, input int ch);
        return 11'((idx * 37 + ch * 293 + 5) % 2048);
    endfunction

    always @(negedge clk) conv_data_i = conv_word($time / PERIOD, int'(ch_sel_o));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_group(input int src, input logic [1:0] code);
        int n, hcount, bcount, cscount, cs_bad, done_j, late_hold;
        longint idx0;
        n = (code == 2'd0) ? 2 : (code == 2'd1) ? 3 : 4;
        hcount = 0; bcount = 0; cscount = 0; cs_bad = 0; done_j = 0; late_hold = 0;
        @(negedge clk);
        grp_size = code;
        idx0 = $time / PERIOD;
        case (src)
            0: start_cmd = 1'b1;
            1: start_pin = 1'b1;
            default: begin sync_en = 1'b1; pwm_sync = 1'b1; end
        endcase
        for (int j = 1; j <= 200; j++) begin
            @(negedge clk);
            if (j == 1)  begin start_cmd = 1'b0; pwm_sync = 1'b0; sync_en = 1'b1; end
            if (j == 3)  start_pin = 1'b0;
            if (j == 5)  grp_size = ~code;      // R11 disturbance
            if (j == 50) start_cmd = 1'b1;      // R8 disturbance
            if (j == 51) start_cmd = 1'b0;
            if (j == 80) pwm_sync = 1'b1;       // R8 disturbance
            if (j == 81) pwm_sync = 1'b0;
            if (hold_o) begin
                hcount++;
                if (j > HOLD) late_hold++;
            end
            if (busy_o) bcount++;
            if (conv_start_o) begin
                if (j != HOLD + 1 + CONV * cscount || int'(ch_sel_o) != cscount) cs_bad++;
                cscount++;
            end
            if (done_o && done_j == 0) done_j = j;
        end
        sync_en = 1'b0;
        chk(hcount == HOLD && late_hold == 0, "R2 hold cycles", hcount, HOLD);
        chk(bcount == HOLD + CONV * n, "R4 R1 R11 busy cycles", bcount, HOLD + CONV * n);
        chk(cscount == n, "R3 conversions", cscount, n);
        chk(cs_bad == 0, "R3 convert-start timing/channel", cs_bad, 0);
        chk(done_j == HOLD + CONV * n + 1, "R9 done position", done_j, HOLD + CONV * n + 1);
        chk(busy_o == 1'b0, "R8 no queued trigger", int'(busy_o), 0);
        case (src)
            0: chk(bcount > 0, "R7 host command trigger", bcount, HOLD + CONV * n);
            1: chk(bcount > 0, "R7 pin edge trigger", bcount, HOLD + CONV * n);
            default: chk(bcount > 0, "R7 pwm sync trigger", bcount, HOLD + CONV * n);
        endcase
        for (int k = n - 1; k >= 0; k--) begin
            logic [10:0] w;
            logic [11:0] e;
            rd_sel = 2'(k);
            #1;
            w = conv_word(idx0 + HOLD + CONV * (k + 1), k);
            e = {w[10], w};
            chk(rd_data == e, "R5 R6 result", int'(rd_data), int'(e));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(busy_o == 0 && hold_o == 0 && conv_start_o == 0 && done_o == 0,
            "R10 idle outputs", int'({busy_o, hold_o, conv_start_o, done_o}), 0);
        for (int k = 0; k < 4; k++) begin
            rd_sel = 2'(k);
            #1;
            chk(rd_data == 12'd0, "R10 cleared result", int'(rd_data), 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: pwm_sync while disabled starts nothing
        sync_en = 1'b0;
        pwm_sync = 1'b1;
        @(negedge clk);
        pwm_sync = 1'b0;
        chk(busy_o == 1'b0, "R7 gated pwm sync", int'(busy_o), 0);
        @(negedge clk);
        chk(busy_o == 1'b0, "R7 gated pwm sync later", int'(busy_o), 0);
        for (int s = 0; s < 3; s++)
            for (int c = 0; c < 4; c++)
                run_group(s, 2'(c));
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        errs++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule